// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller

This block gathers a parameterised number of interrupt request lines into one pending set and selects a single source to serve. It passes that choice to a processor through one interrupt flag. A request pends on the rising edge of its line, so a line that is held high pends only once. A per-source enable mask decides which sources may pend. The source with the lowest index always has the highest priority. The selected source appears on a one-hot current vector and stays there until the processor acknowledges it. A higher-priority request that arrives while another source is in service waits its turn.

Disabling a pending source through its mask bit discards the request for good. A global clear input empties the pending set. The reset is asynchronous, and a parameter sets its active level. After an acknowledge, the current vector is empty for one cycle, and then the next source is loaded.

Top module: `intc_top`

## Requirements
- R1: While reset is at its active level (parameter `RST_LEVEL`), pending, current and irq are all zero at once, without waiting for a clock edge.
- R2: A pending bit is set by the clock edge at which its request line is sampled high after having been sampled low. A line held high pends exactly once, even after it has been serviced.
- R3: A mask bit of 1 enables its source and 0 disables it. A request on a disabled source is not recorded. Clearing a mask bit drops that pending bit at the next edge, and setting the mask bit again does not restore it.
- R4: When current is zero and enabled pending bits exist, the next edge loads current with the lowest-index enabled pending bit (bit i of current stands for source i).
- R5: Current is always either zero or one-hot.
- R6: While current is non-zero, it keeps its value when acknowledge is low, clear-pending is low and its own mask bit is set, even if higher-priority requests arrive.
- R7: Acknowledge while current is non-zero clears both current and that source's pending bit at the next edge. The next-priority source is loaded at the edge after that.
- R8: If a new rising edge of the in-service source coincides with its acknowledge, the pending bit stays set and that source is selected again after current has been empty for one cycle.
- R9: Clear-pending empties pending and current at the next edge. A request edge sampled in that same cycle is still recorded.
- R10: irq is high exactly when at least one pending bit is set. An in-service source keeps its pending bit until it is retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active at level `RST_LEVEL` |
| intMask | input | NUM_SRC | Per-source enable, 1 = enabled |
| intReq | input | NUM_SRC | Request lines, rising edge pends |
| pendingOut | output | NUM_SRC | Pending set |
| currentOut | output | NUM_SRC | One-hot in-service source, or zero |
| irq | output | 1 | Interrupt flag to the processor |
| ack | input | 1 | Retire the in-service source |
| clrPending | input | 1 | Empty the pending set and current |

## Verification
A corrupted pending register shows on pendingOut and irq one edge after the stimulus that caused it. It shows again one edge later as the wrong source, or a missing source, loaded into currentOut. A wrong priority pick or a failed retire appears in the service order: the bench sweeps every request pattern of a four-source build and checks each acknowledge step against the ascending set-bit order. A preemption fault or a one-hot fault appears on currentOut within one edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef struct packed {
    logic loadCur;   // copy the priority pick into current
    logic clrCur;    // retire the current source
    logic clrAll;    // empty the pending set
  } intcStrobe_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic        ack,
  input  logic        clrPending,
  input  logic        busy,
  input  logic        curMaskedOff,
  input  logic        anyEligible,
  output intcStrobe_t strb
);
  always_comb begin
    strb.clrAll  = clrPending;
    strb.clrCur  = busy && (ack || clrPending || curMaskedOff);
    strb.loadCur = !busy && !clrPending && anyEligible;
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rstAct,
  input  logic [NUM_SRC-1:0] intMask,
  input  logic [NUM_SRC-1:0] intReq,
  input  intcStrobe_t        strb,
  output logic [NUM_SRC-1:0] pending,
  output logic [NUM_SRC-1:0] current,
  output logic               busy,
  output logic               curMaskedOff,
  output logic               anyEligible
);
  logic [NUM_SRC-1:0] reqPrev;
  logic [NUM_SRC-1:0] reqRise;
  logic [NUM_SRC-1:0] eligible;
  logic [NUM_SRC-1:0] pick;
  logic [NUM_SRC:0]   seenBelow;
  logic [NUM_SRC-1:0] pendKeep;
  logic [NUM_SRC-1:0] pendNext;
  logic [NUM_SRC-1:0] curNext;

  assign reqRise  = intReq & ~reqPrev;
  assign eligible = pending & intMask;

  // Lowest index wins: a bit is picked when no lower bit is eligible.
  assign seenBelow[0] = 1'b0;
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    assign pick[i]        = eligible[i] & ~seenBelow[i];
    assign seenBelow[i+1] = seenBelow[i] | eligible[i];
  end

  assign anyEligible  = seenBelow[NUM_SRC];
  assign busy         = |current;
  assign curMaskedOff = |(current & ~intMask);

  always_comb begin
    if (strb.clrAll)      pendKeep = '0;
    else if (strb.clrCur) pendKeep = pending & ~current;
    else                  pendKeep = pending;
    pendNext = (pendKeep | reqRise) & intMask;
    if (strb.clrCur)       curNext = '0;
    else if (strb.loadCur) curNext = pick;
    else                   curNext = current;
  end

  always_ff @(posedge clk or posedge rstAct) begin
    if (rstAct) begin
      reqPrev <= '0;
      pending <= '0;
      current <= '0;
    end else begin
      reqPrev <= intReq;
      pending <= pendNext;
      current <= curNext;
    end
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int   NUM_SRC   = 8,
  parameter logic RST_LEVEL = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] intMask,
  input  logic [NUM_SRC-1:0] intReq,
  output logic [NUM_SRC-1:0] pendingOut,
  output logic [NUM_SRC-1:0] currentOut,
  output logic               irq,
  input  logic               ack,
  input  logic               clrPending
);
  logic        rstAct;
  logic        busy;
  logic        curMaskedOff;
  logic        anyEligible;
  intcStrobe_t strb;

  assign rstAct = (rst == RST_LEVEL);

  intc_ctrl u_ctrl (
    .ack(ack), .clrPending(clrPending), .busy(busy),
    .curMaskedOff(curMaskedOff), .anyEligible(anyEligible), .strb(strb)
  );

  intc_datapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk(clk), .rstAct(rstAct), .intMask(intMask), .intReq(intReq),
    .strb(strb), .pending(pendingOut), .current(currentOut),
    .busy(busy), .curMaskedOff(curMaskedOff), .anyEligible(anyEligible)
  );

  assign irq = |pendingOut;
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int   NUM_SRC   = 8,
  parameter logic RST_LEVEL = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] intMask,
  input logic [NUM_SRC-1:0] pendingOut,
  input logic [NUM_SRC-1:0] currentOut,
  input logic               ack,
  input logic               clrPending
);
  logic rstAct;
  assign rstAct = (rst == RST_LEVEL);

  AST_CUR_ONEHOT: assert property (@(posedge clk) disable iff (rstAct)
    $onehot0(currentOut)); // R5
  AST_CUR_IN_PEND: assert property (@(posedge clk) disable iff (rstAct)
    (currentOut & ~pendingOut) == '0); // R10
  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (rstAct)
    (currentOut != '0 && !ack && !clrPending && (currentOut & ~intMask) == '0)
    |=> $stable(currentOut)); // R6
  AST_ACK_RETIRE: assert property (@(posedge clk) disable iff (rstAct)
    (currentOut != '0 && ack) |=> currentOut == '0); // R7
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rstAct)
    clrPending |=> currentOut == '0); // R9
  AST_IDLE_LOAD: assert property (@(posedge clk) disable iff (rstAct)
    (currentOut == '0 && !clrPending && (pendingOut & intMask) != '0)
    |=> currentOut != '0); // R4
  AST_MASK_DROP: assert property (@(posedge clk) disable iff (rstAct)
    !clrPending |=> (pendingOut & ~$past(intMask)) == '0); // R3
endmodule

bind intc_top intc_checker #(.NUM_SRC(NUM_SRC), .RST_LEVEL(RST_LEVEL)) u_chk (
  .clk(clk), .rst(rst), .intMask(intMask), .pendingOut(pendingOut),
  .currentOut(currentOut), .ack(ack), .clrPending(clrPending)
);

// File: tb/intc_top_tb.sv
module intc_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] intMask = '1;
  logic [N-1:0] intReq = '0;
  logic [N-1:0] pendingOut, currentOut;
  logic irq;
  logic ack = 1'b0;
  logic clrPending = 1'b0;
  int total = 0;
  int bad = 0;

  intc_top #(.NUM_SRC(N), .RST_LEVEL(1'b1)) u_dut (
    .clk(clk), .rst(rst), .intMask(intMask), .intReq(intReq),
    .pendingOut(pendingOut), .currentOut(currentOut), .irq(irq),
    .ack(ack), .clrPending(clrPending)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic retire();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R1 pend", 32'(pendingOut), 0);
    chk("R1 cur", 32'(currentOut), 0);
    chk("R1 irq", 32'(irq), 0);
    rst = 1'b0;
    tick();

    // R4 R7 R10: every request pattern serviced in ascending index order
    for (int p = 1; p < (1 << N); p++) begin
      logic [N-1:0] rem;
      rem = N'(p);
      intReq = N'(p); tick(); intReq = '0;
      chk("R2 pend", 32'(pendingOut), 32'(rem));
      chk("R10 irq", 32'(irq), 1);
      chk("R4 idle", 32'(currentOut), 0);
      tick();
      for (int i = 0; i < N; i++) begin
        if (rem[i]) begin
          chk("R4 pick", 32'(currentOut), 32'(1 << i));
          chk("R7 pend", 32'(pendingOut), 32'(rem));
          retire();
          rem[i] = 1'b0;
          chk("R7 cur", 32'(currentOut), 0);
          chk("R7 pend", 32'(pendingOut), 32'(rem));
          tick();
        end
      end
      chk("R10 idle", 32'(irq), 0);
      chk("R7 done", 32'(currentOut), 0);
    end

    // R2: held-high line pends once
    intReq = 4'b0100; tick(); tick();
    chk("R2 held", 32'(currentOut), 32'h4);
    retire(); tick(); tick();
    chk("R2 once", 32'(pendingOut), 0);
    chk("R2 once cur", 32'(currentOut), 0);
    intReq = '0; tick();

    // R6: no preemption
    intReq = 4'b1000; tick(); intReq = '0; tick();
    chk("R6 low", 32'(currentOut), 32'h8);
    intReq = 4'b0001; tick(); intReq = '0;
    chk("R6 pend", 32'(pendingOut), 32'h9);
    tick(); tick();
    chk("R6 hold", 32'(currentOut), 32'h8);
    retire();
    chk("R7 gap", 32'(currentOut), 0);
    tick();
    chk("R7 next", 32'(currentOut), 32'h1);
    retire(); tick();
    chk("R7 empty", 32'(pendingOut), 0);

    // R3: mask drops and blocks
    intReq = 4'b0101; tick(); intReq = '0; tick();
    chk("R3 setup", 32'(currentOut), 32'h1);
    intMask = 4'b1011; tick();
    chk("R3 drop", 32'(pendingOut), 32'h1);
    intMask = 4'b1111; tick();
    chk("R3 no return", 32'(pendingOut), 32'h1);
    intMask = 4'b0111; intReq = 4'b1000; tick(); intReq = '0;
    chk("R3 blocked", 32'(pendingOut), 32'h1);
    intMask = 4'b1110; tick();
    chk("R3 cur drop", 32'(currentOut), 0);
    chk("R3 cur pend", 32'(pendingOut), 0);
    intMask = 4'b1111; tick();

    // R8: re-request coinciding with acknowledge
    intReq = 4'b0010; tick(); intReq = '0; tick();
    chk("R8 setup", 32'(currentOut), 32'h2);
    ack = 1'b1; intReq = 4'b0010; tick(); ack = 1'b0; intReq = '0;
    chk("R8 pend", 32'(pendingOut), 32'h2);
    chk("R8 gap", 32'(currentOut), 0);
    tick();
    chk("R8 again", 32'(currentOut), 32'h2);
    retire(); tick();

    // R9: clear-pending with a coincident edge
    intReq = 4'b1011; tick(); intReq = '0; tick();
    chk("R9 setup", 32'(currentOut), 32'h1);
    clrPending = 1'b1; intReq = 4'b0100; tick(); clrPending = 1'b0; intReq = '0;
    chk("R9 pend", 32'(pendingOut), 32'h4);
    chk("R9 cur", 32'(currentOut), 0);
    tick();
    chk("R9 reload", 32'(currentOut), 32'h4);

    // R1: asynchronous reset between edges
    #2 rst = 1'b1;
    #1;
    chk("R1 async pend", 32'(pendingOut), 0);
    chk("R1 async cur", 32'(currentOut), 0);
    chk("R1 async irq", 32'(irq), 0);
    tick(); rst = 1'b0; tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule